// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block sits behind the four-wire serial port of a 128-byte non-volatile memory. It takes an 8-bit command from the bus master, then any address and data bytes, and turns them into single-cycle requests to two neighbouring units. A status/protection unit sets and clears the write-enable latch and stores a new status byte. A page-write unit collects bytes for one 8-byte page and programs them. For the two read commands the block sends the status byte, or a stream of array bytes, back on the serial output.

All bus pins are sampled with a fast system clock, and SCK edges are detected in that clock domain. The block accepts both clock polarities that sample on the rising edge: SCK idle low, and SCK idle high. A hold input lets the master pause a transfer partway through and share the bus with other slaves. The block models no storage array. The array read port, the busy flag and the status byte are inputs, and a simple register model can drive them.

Top module: `spi_mem_front`

## Requirements
- R1: SI is sampled on rising SCK and SO changes on falling SCK, most significant bit first, with SCK idling either low or high between frames.
- R2: The command byte has the form 0000_x_bbb, and bit 3 has no effect. The low three bits select the command: 110 set write enable, 100 clear write enable, 101 read status, 001 write status, 011 read array, 010 write array.
- R3: A command byte with a non-zero upper nibble, or with low bits 000 or 111, is invalid. The block then keeps so_oe low until chip select rises, and it issues no request.
- R4: While cs_n is high, so_oe is low. Raising cs_n discards a partial byte, and the next falling edge of cs_n starts a new command byte.
- R5: Read array takes one address byte and ignores its top bit. It then streams bytes from that address upward, wrapping from 0x7F to 0x00, until cs_n rises.
- R6: Read status repeats the status_in byte for as long as SCK keeps running.
- R7: While hold_n is low, SCK edges have no effect and so_oe is low. When hold_n returns high, the transfer continues from the same bit.
- R8: Set write enable, clear write enable and write status each raise their request one clock after cs_n rises. This happens only if the frame ended on a byte boundary. Write status also needs at least one data byte, and wr_data then carries the last byte received.
- R9: Write array raises wbyte_req for each complete data byte, with its target address on wr_addr. The address increments in its low three bits and wraps within its 8-byte page. wcommit_req pulses after cs_n rises only if at least one data byte arrived and the frame ended on a byte boundary.
- R10: While busy is high when the command byte completes, every command except read status is treated as invalid.
- R11: After reset, so_oe is low and no request is raised.
- R12: Each request is a single-cycle pulse, and at most one request is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| busy | input | 1 | Write cycle in progress |
| status_in | input | 8 | Status byte returned by read status |
| mem_rdata | input | 8 | Array byte at mem_raddr |
| mem_raddr | output | 7 | Array read address |
| so | output | 1 | Serial data out, valid when so_oe is high |
| so_oe | output | 1 | Output enable for the SO pad (low means high impedance) |
| wren_req | output | 1 | Set write-enable request |
| wrdi_req | output | 1 | Clear write-enable request |
| wrsr_req | output | 1 | Write status request, value on wr_data |
| wbyte_req | output | 1 | Page-write data byte strobe |
| wcommit_req | output | 1 | Page-write commit strobe |
| wr_addr | output | 7 | Address for wbyte_req |
| wr_data | output | 8 | Data for wbyte_req or wrsr_req |

## Verification
A bit counter that is off by one shows up at once, in the very next byte. The read data on SO comes out rotated, and a write request carries a shifted value, or a complete write frame is wrongly treated as incomplete. A wrong address register shows when a long read crosses 0x7F or a write crosses its page boundary, within one byte of the crossing. A decoder or hold-gating fault shows at the first SCK edge after it. Either SO becomes driven when it should stay high impedance, or a request appears when cs_n rises with no matching entry expected.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int BYTE_BITS = 8;
    localparam int ARR_ADDR_BITS = 7;
    localparam int PAGE_BITS = 3;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [2:0] {
        CMD_BAD,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    typedef enum logic [1:0] {
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_DEAD
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sel;
        logic live;
        logic si;
    } bus_ev_t;

    // fields = {op[7:4], op[2:0]}; bit 3 never reaches the decoder
    function automatic cmd_e decode_op(input logic [6:0] fields, input logic busy);
        cmd_e c;
        if (fields[6:3] != 4'h0) begin
            c = CMD_BAD;
        end else begin
            case (fields[2:0])
                3'b110:  c = CMD_WREN;
                3'b100:  c = CMD_WRDI;
                3'b101:  c = CMD_RDSR;
                3'b001:  c = CMD_WRSR;
                3'b011:  c = CMD_READ;
                3'b010:  c = CMD_WRITE;
                default: c = CMD_BAD;
            endcase
        end
        if (busy && c != CMD_RDSR) c = CMD_BAD;
        return c;
    endfunction

    function automatic logic is_stream(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_RDSR);
    endfunction

endpackage

// File: rtl/spi_bus_sync.sv
module spi_bus_sync
    import spi_mem_pkg::*;
#(
    parameter int SYNC_N = SYNC_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    input  logic    hold_n,
    output bus_ev_t ev
);
    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] RST_V = 4'b1001;  // {cs_n, sck, si, hold_n}

    logic [NSIG-1:0] raw;
    logic [NSIG-1:0] synced;
    logic            sck_d;
    logic            cs_d;

    assign raw = {cs_n, sck, si, hold_n};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        logic [SYNC_N-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= {SYNC_N{RST_V[g]}};
            else     chain <= {chain[SYNC_N-2:0], raw[g]};
        end
        assign synced[g] = chain[SYNC_N-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= synced[2];
            cs_d  <= synced[3];
        end
    end

    always_comb begin
        ev.sel   = ~synced[3];
        ev.live  = synced[0];
        ev.si    = synced[1];
        ev.rise  = synced[2] & ~sck_d & ev.sel & ev.live;
        ev.fall  = ~synced[2] & sck_d & ev.sel & ev.live;
        ev.start = cs_d & ~synced[3];
        ev.stop  = ~cs_d & synced[3];
    end

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_mem_pkg::*;
#(
    parameter int BYTE_W = BYTE_BITS,
    parameter int ADDR_W = ARR_ADDR_BITS,
    parameter int PAGE_W = PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              start,
    input  logic              stop,
    input  logic              sel,
    input  logic              live,
    input  logic              si_s,
    input  logic              busy,
    output cmd_e              cmd,
    output phase_e            phase,
    output logic              bit_zero,
    output logic [ADDR_W-1:0] addr,
    output logic              wren_stb,
    output logic              wrdi_stb,
    output logic              wrsr_stb,
    output logic              wbyte_stb,
    output logic              commit_stb,
    output logic [ADDR_W-1:0] wbyte_addr,
    output logic [BYTE_W-1:0] wdata
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shin;
    logic [BYTE_W-1:0] nxt;
    logic              got_data;
    logic              aligned;
    logic [ADDR_W-1:0] page_next;
    cmd_e              op_cmd;

    assign nxt       = {shin[BYTE_W-2:0], si_s};
    assign bit_zero  = (bit_cnt == '0);
    assign aligned   = bit_zero;
    assign page_next = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
    assign op_cmd    = decode_op({nxt[7:4], nxt[2:0]}, busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            shin       <= '0;
            cmd        <= CMD_BAD;
            phase      <= PH_OPC;
            addr       <= '0;
            got_data   <= 1'b0;
            wren_stb   <= 1'b0;
            wrdi_stb   <= 1'b0;
            wrsr_stb   <= 1'b0;
            wbyte_stb  <= 1'b0;
            commit_stb <= 1'b0;
            wbyte_addr <= '0;
            wdata      <= '0;
        end else begin
            wren_stb   <= 1'b0;
            wrdi_stb   <= 1'b0;
            wrsr_stb   <= 1'b0;
            wbyte_stb  <= 1'b0;
            commit_stb <= 1'b0;
            if (stop) begin
                if (aligned) begin
                    wren_stb   <= (cmd == CMD_WREN) && (phase == PH_DATA);
                    wrdi_stb   <= (cmd == CMD_WRDI) && (phase == PH_DATA);
                    wrsr_stb   <= (cmd == CMD_WRSR) && got_data;
                    commit_stb <= (cmd == CMD_WRITE) && got_data;
                end
                bit_cnt  <= '0;
                phase    <= PH_OPC;
                cmd      <= CMD_BAD;
                got_data <= 1'b0;
            end else if (start) begin
                bit_cnt  <= '0;
                phase    <= PH_OPC;
                cmd      <= CMD_BAD;
                got_data <= 1'b0;
            end else if (rise) begin
                shin    <= nxt;
                bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CNT_W'(1);
                if (bit_cnt == LAST) begin
                    unique case (phase)
                        PH_OPC: begin
                            cmd <= op_cmd;
                            if (op_cmd == CMD_BAD)
                                phase <= PH_DEAD;
                            else if (op_cmd == CMD_READ || op_cmd == CMD_WRITE)
                                phase <= PH_ADDR;
                            else
                                phase <= PH_DATA;
                        end
                        PH_ADDR: begin
                            addr  <= nxt[ADDR_W-1:0];
                            phase <= PH_DATA;
                        end
                        PH_DATA: begin
                            case (cmd)
                                CMD_READ: addr <= addr + ADDR_W'(1);
                                CMD_WRSR: begin
                                    wdata    <= nxt;
                                    got_data <= 1'b1;
                                end
                                CMD_WRITE: begin
                                    wdata      <= nxt;
                                    wbyte_addr <= addr;
                                    wbyte_stb  <= 1'b1;
                                    addr       <= page_next;
                                    got_data   <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R7: a paused bus leaves the bit position untouched
    p_hold_keeps_count_r7: assert property (@(posedge clk) disable iff (rst)
        (sel && !live) |=> $stable(bit_cnt));

    // R4: a deselected bus always sits at the first bit of a command
    p_idle_at_opcode_r4: assert property (@(posedge clk) disable iff (rst)
        (!sel && !stop) |-> (bit_zero && phase == PH_OPC));

    // R9: consecutive byte strobes stay in the same page
    p_page_confined_r9: assert property (@(posedge clk) disable iff (rst)
        (wbyte_stb && $past(wbyte_stb, 1) == 1'b0 && phase == PH_DATA && cmd == CMD_WRITE)
            |-> (addr[ADDR_W-1:PAGE_W] == wbyte_addr[ADDR_W-1:PAGE_W]));

endmodule

// File: rtl/spi_so_shift.sv
module spi_so_shift
    import spi_mem_pkg::*;
#(
    parameter int BYTE_W = BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              start,
    input  logic              stop,
    input  logic              sel,
    input  logic              live,
    input  cmd_e              cmd,
    input  phase_e            phase,
    input  logic              bit_zero,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [BYTE_W-1:0] status_in,
    output logic              so,
    output logic              so_oe
);
    logic [BYTE_W-1:0] sh;
    logic              live_out;
    logic              load;

    assign load  = fall && (phase == PH_DATA) && is_stream(cmd) && bit_zero;
    assign so    = sh[BYTE_W-1];
    assign so_oe = sel & live & live_out;

    always_ff @(posedge clk) begin
        if (rst || start || stop) begin
            sh       <= '0;
            live_out <= 1'b0;
        end else if (load) begin
            sh       <= (cmd == CMD_RDSR) ? status_in : mem_rdata;
            live_out <= 1'b1;
        end else if (fall && live_out && !bit_zero) begin
            sh <= {sh[BYTE_W-2:0], 1'b0};
        end
    end

    // R3: an invalid command never drives the output
    p_dead_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DEAD) |-> !so_oe);

    // R1: output bits only move on a falling clock edge
    p_so_moves_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
        (so_oe && $past(so_oe) && !$past(fall)) |-> $stable(so));

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front
    import spi_mem_pkg::*;
#(
    parameter int BYTE_W = BYTE_BITS,
    parameter int ADDR_W = ARR_ADDR_BITS,
    parameter int PAGE_W = PAGE_BITS,
    parameter int SYNC_N = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic              busy,
    input  logic [BYTE_W-1:0] status_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              so,
    output logic              so_oe,
    output logic              wren_req,
    output logic              wrdi_req,
    output logic              wrsr_req,
    output logic              wbyte_req,
    output logic              wcommit_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    bus_ev_t ev;
    cmd_e    cmd;
    phase_e  phase;
    logic    bit_zero;

    spi_bus_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n), .ev(ev)
    );

    spi_cmd_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk(clk), .rst(rst), .rise(ev.rise), .start(ev.start), .stop(ev.stop),
        .sel(ev.sel), .live(ev.live), .si_s(ev.si), .busy(busy),
        .cmd(cmd), .phase(phase), .bit_zero(bit_zero), .addr(mem_raddr),
        .wren_stb(wren_req), .wrdi_stb(wrdi_req), .wrsr_stb(wrsr_req),
        .wbyte_stb(wbyte_req), .commit_stb(wcommit_req),
        .wbyte_addr(wr_addr), .wdata(wr_data)
    );

    spi_so_shift #(.BYTE_W(BYTE_W)) u_out (
        .clk(clk), .rst(rst), .fall(ev.fall), .start(ev.start), .stop(ev.stop),
        .sel(ev.sel), .live(ev.live), .cmd(cmd), .phase(phase), .bit_zero(bit_zero),
        .mem_rdata(mem_rdata), .status_in(status_in), .so(so), .so_oe(so_oe)
    );

    // R4: deselected means high impedance
    p_so_idle_cs_r4: assert property (@(posedge clk) disable iff (rst)
        !ev.sel |-> !so_oe);

    // R7: paused means high impedance
    p_so_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ev.live |-> !so_oe);

    // R12: requests never overlap
    p_req_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wren_req, wrdi_req, wrsr_req, wbyte_req, wcommit_req}));

    // R12: requests last one cycle
    p_req_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        (wren_req || wrdi_req || wrsr_req || wcommit_req) |=>
            !(wren_req || wrdi_req || wrsr_req || wcommit_req));

    // R8, R9: frame-level requests follow the end of a frame
    p_req_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (wren_req || wrdi_req || wrsr_req || wcommit_req) |-> $past(ev.stop));

endmodule

// File: tb/test_spi_mem_front.sv
module test_spi_mem_front;
    localparam int HP = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic [7:0] mem_rdata;
    logic [6:0] mem_raddr;
    logic       so, so_oe;
    logic       wren_req, wrdi_req, wrsr_req, wbyte_req, wcommit_req;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] mem [128];

    always #4 clk = ~clk;
    assign mem_rdata = mem[mem_raddr];

    spi_mem_front i_spi_mem_front (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .busy(busy), .status_in(status_in), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .so(so), .so_oe(so_oe), .wren_req(wren_req), .wrdi_req(wrdi_req),
        .wrsr_req(wrsr_req), .wbyte_req(wbyte_req), .wcommit_req(wcommit_req),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int  nchk = 0, nfail = 0;
    bit  done = 1'b0;
    bit  oe_any, oe_all;

    typedef struct {int kind; int addr; int data; string req;} exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic want(input int kind, input int addr, input int data, input string req);
        exp_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        q.push_back(e);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: 1 wren, 2 wrdi, 3 wrsr, 4 wbyte, 5 commit
    always @(negedge clk) begin : mon
        int   k;
        int   act, expv;
        exp_t e;
        k = 0;
        if (!rst) begin
            if (wren_req)    k = 1;
            if (wrdi_req)    k = 2;
            if (wrsr_req)    k = 3;
            if (wbyte_req)   k = 4;
            if (wcommit_req) k = 5;
            if (k != 0) begin
                act = (k << 16) | (int'(wr_addr) << 8) | int'(wr_data);
                if (q.size() == 0) begin
                    chk(1'b0, "R12 unexpected request", act, 0);
                end else begin
                    e = q.pop_front();
                    expv = (e.kind << 16) | ((e.addr < 0 ? int'(wr_addr) : e.addr) << 8)
                         | (e.data < 0 ? int'(wr_data) : e.data);
                    chk(act == expv, e.req, act, expv);
                end
            end
        end
    end

    task automatic put_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b > 7 - nb; b--) begin
            sck = 1'b0;
            si  = tx[b];
            tick(HP);
            rx[b]  = so;
            oe_any = oe_any | so_oe;
            oe_all = oe_all & so_oe;
            sck = 1'b1;
            tick(HP);
        end
    endtask

    task automatic put(input logic [7:0] tx);
        logic [7:0] rx;
        put_bits(tx, 8, rx);
    endtask

    task automatic frame_open(input bit mode3);
        sck = mode3;
        tick(HP);
        cs_n = 1'b0;
        tick(HP);
        oe_any = 1'b0;
        oe_all = 1'b1;
    endtask

    task automatic frame_close(input bit mode3);
        if (!mode3) begin
            sck = 1'b0;
            tick(HP);
        end
        cs_n = 1'b1;
        tick(2 * HP);
    endtask

    task automatic queue_empty(input string req);
        tick(4);
        chk(q.size() == 0, req, q.size(), 0);
        q.delete();
    endtask

    task automatic do_read(input logic [7:0] abyte, input int n, input bit mode3, input string req);
        logic [7:0] rx;
        int         a;
        a = int'(abyte[6:0]);
        frame_open(mode3);
        put(8'h03);
        put(abyte);
        for (int k = 0; k < n; k++) begin
            oe_all = 1'b1;
            put_bits(8'h00, 8, rx);
            chk(oe_all && rx == mem[(a + k) & 127], req, {oe_all, rx}, {1'b1, mem[(a + k) & 127]});
        end
        frame_close(mode3);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin : watchdog
        tick(100000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : main
        logic [7:0] rx;
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) & 255);
        tick(5);
        rst = 1'b0;
        tick(4);
        // R11: reset state
        chk(so_oe == 1'b0, "R11 so_oe after reset", so_oe, 0);
        chk(!(wren_req | wrdi_req | wrsr_req | wbyte_req | wcommit_req),
            "R11 requests after reset", 1, 0);

        // R2: set write enable, plain and with bit 3 set
        want(1, -1, -1, "R2 wren 06");
        frame_open(0); put(8'h06); frame_close(0);
        want(1, -1, -1, "R2 wren 0E bit3 ignored");
        frame_open(1); put(8'h0E); frame_close(1);
        want(2, -1, -1, "R2 wrdi 04");
        frame_open(0); put(8'h04); frame_close(0);
        queue_empty("R2 queue drained");

        // R8: write status complete and incomplete
        want(3, -1, 8'h0C, "R8 wrsr data");
        frame_open(0); put(8'h01); put(8'h0C); frame_close(0);
        frame_open(0); put(8'h01); frame_close(0);
        frame_open(0); put(8'h01); put_bits(8'hFF, 5, rx); frame_close(0);
        queue_empty("R8 incomplete wrsr ignored");

        // R9: page write with wrap inside page 0
        want(4, 8'h06, 8'hA1, "R9 byte at 06");
        want(4, 8'h07, 8'hB2, "R9 byte at 07");
        want(4, 8'h00, 8'hC3, "R9 page wrap to 00");
        want(5, -1, -1, "R9 commit");
        frame_open(0); put(8'h02); put(8'h06); put(8'hA1); put(8'hB2); put(8'hC3); frame_close(0);
        queue_empty("R9 full write");
        want(4, 8'h10, 8'h55, "R9 byte before abort");
        frame_open(1); put(8'h0A); put(8'h10); put(8'h55); put_bits(8'hAA, 3, rx); frame_close(1);
        queue_empty("R9 partial write no commit");

        // R5, R1: reads with top-address wrap, both clock polarities
        do_read(8'h7E, 3, 1'b0, "R5 read wrap mode0");
        do_read(8'hFD, 4, 1'b1, "R5 R1 read addr msb ignored mode3");

        // R6: repeated status
        status_in = 8'hA5;
        frame_open(0); put(8'h05);
        for (int k = 0; k < 3; k++) begin
            oe_all = 1'b1;
            put_bits(8'h00, 8, rx);
            chk(oe_all && rx == 8'hA5, "R6 status repeat", rx, 8'hA5);
        end
        frame_close(0);
        status_in = 8'h3C;
        frame_open(1); put(8'h0D);
        put_bits(8'h00, 8, rx);
        chk(rx == 8'h3C, "R6 R1 status mode3", rx, 8'h3C);
        frame_close(1);

        // R3: invalid command bytes
        frame_open(0); put(8'h07); put(8'h12); put(8'h00); frame_close(0);
        chk(!oe_any, "R3 low bits 111 quiet", oe_any, 0);
        frame_open(0); put(8'h16); put(8'h00); frame_close(0);
        chk(!oe_any, "R3 upper nibble quiet", oe_any, 0);
        queue_empty("R3 no request");

        // R4: aborted frame then a fresh command
        frame_open(0); put_bits(8'h06, 3, rx); frame_close(0);
        chk(so_oe == 1'b0, "R4 deselected quiet", so_oe, 0);
        want(1, -1, -1, "R4 counter restart");
        frame_open(0); put(8'h06); frame_close(0);
        queue_empty("R4 abort no request");

        // R10: busy blocks all but read status
        busy = 1'b1;
        frame_open(0); put(8'h03); put(8'h05); put(8'h00); frame_close(0);
        chk(!oe_any, "R10 read blocked when busy", oe_any, 0);
        frame_open(0); put(8'h06); frame_close(0);
        status_in = 8'h01;
        frame_open(0); put(8'h05); put_bits(8'h00, 8, rx); frame_close(0);
        chk(rx == 8'h01, "R10 status allowed when busy", rx, 8'h01);
        busy = 1'b0;
        queue_empty("R10 no request when busy");

        // R7: hold in the middle of a read
        frame_open(0); put(8'h03); put(8'h20);
        put_bits(8'h00, 8, rx);
        chk(rx == mem[32], "R7 read before hold", rx, mem[32]);
        sck = 1'b0; tick(HP);
        hold_n = 1'b0; tick(HP);
        chk(so_oe == 1'b0, "R7 so_oe while held", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
            si = k[0]; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
        end
        hold_n = 1'b1; tick(HP);
        put_bits(8'h00, 8, rx);
        chk(rx == mem[33], "R7 read resumes after hold", rx, mem[33]);
        frame_close(0);

        // R7: hold in a write between address and data
        want(4, 8'h40, 8'h5A, "R7 write byte after hold");
        want(5, -1, -1, "R7 commit after hold");
        frame_open(0); put(8'h02); put(8'h40);
        sck = 1'b0; tick(HP);
        hold_n = 1'b0; tick(HP);
        for (int k = 0; k < 5; k++) begin
            si = 1'b1; sck = 1'b1; tick(HP); sck = 1'b0; tick(HP);
        end
        hold_n = 1'b1; tick(HP);
        put(8'h5A);
        frame_close(0);
        queue_empty("R7 write hold queue");

        tick(20);
        finish_run();
    end

endmodule